// File: doc/BRIEF.md
# Serial Receive Queue with Trigger Level and Character Timeout

This block holds received bytes for a serial port between the line deserializer and the host. It has two modes. In queue mode, up to 16 bytes wait in arrival order. A trigger flag rises once the fill reaches a level the host selects. A character-timeout flag tells the host that bytes have been sitting unread while the line stayed quiet. In single-register mode, one holding register stands in for the queue, and a new byte overwrites an unread one.

The host reads data through a read strobe. The byte that the next read returns is always visible on `rd_data`. The host reads the line status through a second strobe, which clears the sticky error flags. A configuration write sets the mode bit, the trigger level and a queue flush. The timeout window is four character times. A character time is the bit period in clock cycles multiplied by the frame length, and the frame length comes from the frame-format input.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the block is in single-register mode. `rd_data`, `fill_count` and every flag read 0.
- R2: In queue mode (config bit 0 = 1), bytes leave in arrival order. `rd_data` shows the oldest byte, each read strobe removes it, and `data_ready` is high exactly while `fill_count` is non-zero.
- R3: When the queue holds 16 bytes, an arriving byte is dropped and `overrun_flag` is set. The stored bytes and the count are kept.
- R4: Config bits 7:6 select the trigger level: 00 is 1 byte, 01 is 4, 10 is 8 and 11 is 14. In queue mode, `trig_hit` is high when data is ready and the fill is at or above the level. In single-register mode it follows `data_ready`.
- R5: A break strobe stores a zero byte and sets both `break_flag` and `data_ready`.
- R6: A read that empties the queue clears `data_ready` and `break_flag`. With the queue empty in queue mode, `rd_data` is 0.
- R7: In queue mode, every arrival and every read that leaves bytes behind restarts a window of four character times. When the window ends with the queue non-empty, `timeout_pend` rises in the cycle that ends the window. Any read clears `timeout_pend`, and an empty queue never sets it.
- R8: One character time is `bit_period` × (1 start + 5 + `frame_fmt[1:0]` data + `frame_fmt[3]` parity + 2 stop if `frame_fmt[2]`, else 1 stop). The format and period are sampled when the window restarts.
- R9: A config write with bit 1 set empties the queue, clears `data_ready` and `break_flag`, and cancels a pending or running timeout.
- R10: A config write that changes bit 0 flushes the queue in the same way as R9.
- R11: In single-register mode, a byte that arrives while `data_ready` is set replaces the held byte and sets `overrun_flag`. A read clears `data_ready` and `break_flag`.
- R12: A line-status read strobe clears `overrun_flag` and `break_flag`. A set caused by an arrival in the same cycle takes precedence over this clear.
- R13: `fill_count` is 5 bits wide and reaches 16 when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` has arrived |
| rx_byte | input | 8 | Received byte |
| brk_strobe | input | 1 | One-cycle strobe: a line break was detected |
| rd_strobe | input | 1 | Host data read |
| lsr_rd | input | 1 | Host line-status read |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration value: bit 0 mode, bit 1 flush, bits 7:6 trigger |
| frame_fmt | input | 4 | Frame format: [1:0] data length, [2] two stop bits, [3] parity |
| bit_period | input | 16 | Clock cycles per bit |
| rd_data | output | 8 | Byte that the next read returns |
| data_ready | output | 1 | Data available |
| break_flag | output | 1 | Break received |
| overrun_flag | output | 1 | Byte lost |
| fill_count | output | 5 | Bytes queued |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
On every cycle, the assertions check these relations: the fill bound, the overrun on a full queue, that a break sets its flags, the flush effect, the clearing done by both kinds of read, that `data_ready` agrees with the fill in queue mode, and that a timeout never stands over an empty queue. Only the bench's scenarios can show the rest. These are the byte order and the values returned, the exact cycle in which the timeout rises for a given frame format and bit period, the restart of the window by a partial read, and the threshold of each trigger level. The bench also compares every output against its own model after each of several hundred random operations.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef struct packed {
        logic       en;
        logic [1:0] trig;
    } rxq_cfg_t;

    // bits on the wire for one character
    function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
        logic [3:0] n;
        n = 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]};
        n = n + (fmt[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

    function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
        logic [4:0] lvl;
        case (sel)
            2'b00:   lvl = 5'd1;
            2'b01:   lvl = 5'd4;
            2'b10:   lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer import uart_rxq_pkg::*; #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              cancel,
    input  logic [3:0]        frame_fmt,
    input  logic [TICK_W-1:0] bit_period,
    output logic              expire
);
    localparam int LIM_W = TICK_W + 6;

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic             run;
    } tmr_t;

    tmr_t             t_d, t_q;
    logic [LIM_W-1:0] limit;

    always_comb begin
        limit = (LIM_W'(bit_period) * LIM_W'(frame_bits(frame_fmt))) << 2;
        if (limit == '0) limit = LIM_W'(1);
        expire = t_q.run && (t_q.cnt == LIM_W'(1)) && !restart && !cancel;
        t_d = t_q;
        if (cancel) begin
            t_d.run = 1'b0;
        end else if (restart) begin
            t_d.cnt = limit;
            t_d.run = 1'b1;
        end else if (t_q.run) begin
            if (t_q.cnt == LIM_W'(1)) t_d.run = 1'b0;
            else                      t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue import uart_rxq_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int TICK_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [DATA_W-1:0]            rx_byte,
    input  logic                         brk_strobe,
    input  logic                         rd_strobe,
    input  logic                         lsr_rd,
    input  logic                         cfg_wr,
    input  logic [7:0]                   cfg_data,
    input  logic [3:0]                   frame_fmt,
    input  logic [TICK_W-1:0]            bit_period,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         data_ready,
    output logic                         break_flag,
    output logic                         overrun_flag,
    output logic [$clog2(DEPTH+1)-1:0]   fill_count,
    output logic                         trig_hit,
    output logic                         timeout_pend
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rxq_cfg_t          cfg;
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hold;
        logic              dr;
        logic              brk;
        logic              ovr;
        logic              tmo;
    } state_t;

    state_t            s_d, s_q;
    logic              push, pop, flush, restart, expire, rx_any, fifo_mode;
    logic [DATA_W-1:0] in_byte, head;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        push    = 1'b0;
        pop     = 1'b0;
        rx_any  = rx_valid | brk_strobe;
        in_byte = brk_strobe ? '0 : rx_byte;
        flush   = cfg_wr && ((cfg_data[0] != s_q.cfg.en) || cfg_data[1]);

        if (cfg_wr) begin
            s_d.cfg.en   = cfg_data[0];
            s_d.cfg.trig = cfg_data[7:6];
        end

        if (flush) begin
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.cnt    = '0;
            s_d.dr     = 1'b0;
            s_d.brk    = 1'b0;
            s_d.tmo    = 1'b0;
        end else begin
            if (lsr_rd) begin
                s_d.ovr = 1'b0;
                s_d.brk = 1'b0;
            end
            if (s_q.cfg.en) begin
                if (expire && (s_q.cnt != '0)) s_d.tmo = 1'b1;
                if (rd_strobe) begin
                    s_d.tmo = 1'b0;
                    if (s_q.cnt != '0) begin
                        pop = 1'b1;
                        if (s_q.cnt == CNT_W'(1)) begin
                            s_d.dr  = 1'b0;
                            s_d.brk = 1'b0;
                        end
                    end
                end
                if (rx_any) begin
                    if ((s_q.cnt == CNT_W'(DEPTH)) && !pop) s_d.ovr = 1'b1;
                    else                                  push = 1'b1;
                    s_d.dr = 1'b1;
                    if (brk_strobe) s_d.brk = 1'b1;
                end
                if (push) s_d.wr_ptr = nxt(s_q.wr_ptr);
                if (pop)  s_d.rd_ptr = nxt(s_q.rd_ptr);
                s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
            end else begin
                if (rd_strobe) begin
                    s_d.dr  = 1'b0;
                    s_d.brk = 1'b0;
                end
                if (rx_any) begin
                    if (s_q.dr && !rd_strobe) s_d.ovr = 1'b1;
                    s_d.hold = in_byte;
                    s_d.dr   = 1'b1;
                    if (brk_strobe) s_d.brk = 1'b1;
                end
            end
        end

        restart = !flush && s_q.cfg.en &&
                  (rx_any || (rd_strobe && (s_q.cnt > CNT_W'(1))));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (push),
        .wr_addr (s_q.wr_ptr),
        .wr_data (in_byte),
        .rd_addr (s_q.rd_ptr),
        .rd_data (head)
    );

    rxq_char_timer #(.TICK_W(TICK_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .cancel     (flush),
        .frame_fmt  (frame_fmt),
        .bit_period (bit_period),
        .expire     (expire)
    );

    assign fifo_mode    = s_q.cfg.en;
    assign rd_data      = fifo_mode ? ((s_q.cnt != '0) ? head : '0) : s_q.hold;
    assign data_ready   = s_q.dr;
    assign break_flag   = s_q.brk;
    assign overrun_flag = s_q.ovr;
    assign fill_count   = s_q.cnt;
    assign timeout_pend = s_q.tmo;
    assign trig_hit     = s_q.dr &&
                          (!fifo_mode || (int'(s_q.cnt) >= int'(trig_bytes(s_q.cfg.trig))));
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             brk_strobe,
    input logic             rd_strobe,
    input logic             lsr_rd,
    input logic             cfg_wr,
    input logic [7:0]       cfg_data,
    input logic             fifo_mode,
    input logic [CNT_W-1:0] fill_count,
    input logic             data_ready,
    input logic             break_flag,
    input logic             overrun_flag,
    input logic             trig_hit,
    input logic             timeout_pend
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_count) <= DEPTH); // R13

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode && (int'(fill_count) == DEPTH) && rx_valid && !rd_strobe && !cfg_wr && !lsr_rd
        |=> overrun_flag && (int'(fill_count) == DEPTH)); // R3

    AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_strobe && !cfg_wr |=> break_flag && data_ready); // R5

    AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !timeout_pend); // R7

    AST_TMO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pend |-> (fill_count != '0)); // R7

    AST_READY_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode |-> (data_ready == (fill_count != '0))); // R2

    AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> data_ready); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_data[1] |=> (fill_count == '0) && !data_ready && !timeout_pend); // R9

    AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !rx_valid && !brk_strobe |=> !overrun_flag && !break_flag); // R12
endmodule

bind uart_rx_queue rxq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .brk_strobe   (brk_strobe),
    .rd_strobe    (rd_strobe),
    .lsr_rd       (lsr_rd),
    .cfg_wr       (cfg_wr),
    .cfg_data     (cfg_data),
    .fifo_mode    (fifo_mode),
    .fill_count   (fill_count),
    .data_ready   (data_ready),
    .break_flag   (break_flag),
    .overrun_flag (overrun_flag),
    .trig_hit     (trig_hit),
    .timeout_pend (timeout_pend)
);

// File: tb/tb_uart_rx_queue.sv
module tb_uart_rx_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, brk_strobe = 1'b0, rd_strobe = 1'b0;
    logic        lsr_rd = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  rx_byte = '0, cfg_data = '0;
    logic [3:0]  frame_fmt = 4'b0011;
    logic [15:0] bit_period = 16'd4000;
    logic [7:0]  rd_data;
    logic        data_ready, break_flag, overrun_flag, trig_hit, timeout_pend;
    logic [4:0]  fill_count;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] mq[$];
    logic       m_en = 0, m_dr = 0, m_brk = 0, m_ovr = 0, m_tmo = 0;
    logic [1:0] m_trig = 0;
    logic [7:0] m_hold = 0;

    always #4 clk = ~clk;

    uart_rx_queue dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .brk_strobe(brk_strobe), .rd_strobe(rd_strobe), .lsr_rd(lsr_rd),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .frame_fmt(frame_fmt),
        .bit_period(bit_period), .rd_data(rd_data), .data_ready(data_ready),
        .break_flag(break_flag), .overrun_flag(overrun_flag),
        .fill_count(fill_count), .trig_hit(trig_hit), .timeout_pend(timeout_pend)
    );

    function automatic int lvl(input logic [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    function automatic int flen(input logic [3:0] f);
        return 1 + 5 + int'(f[1:0]) + int'(f[3]) + (f[2] ? 2 : 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int exp_rd, exp_trig;
        exp_rd   = m_en ? ((mq.size() != 0) ? int'(mq[0]) : 0) : int'(m_hold);
        exp_trig = m_en ? int'(m_dr && (mq.size() >= lvl(m_trig))) : int'(m_dr);
        chk(req, "rd_data", int'(rd_data), exp_rd);
        chk(req, "data_ready", int'(data_ready), int'(m_dr));
        chk(req, "break_flag", int'(break_flag), int'(m_brk));
        chk(req, "overrun_flag", int'(overrun_flag), int'(m_ovr));
        chk(req, "fill_count", int'(fill_count), m_en ? mq.size() : 0);
        chk(req, "trig_hit", int'(trig_hit), exp_trig);
        chk(req, "timeout_pend", int'(timeout_pend), int'(m_tmo));
    endtask

    task automatic step(input logic v, input logic [7:0] b, input logic bk,
                        input logic rd, input logic ls, input logic cw, input logic [7:0] cd);
        rx_valid = v; rx_byte = b; brk_strobe = bk; rd_strobe = rd;
        lsr_rd = ls; cfg_wr = cw; cfg_data = cd;
        @(negedge clk);
        rx_valid = 0; brk_strobe = 0; rd_strobe = 0; lsr_rd = 0; cfg_wr = 0;
    endtask

    task automatic m_put(input logic [7:0] b, input logic is_brk);
        if (m_en) begin
            if (mq.size() < 16) mq.push_back(b);
            else m_ovr = 1;
        end else begin
            if (m_dr) m_ovr = 1;
            m_hold = b;
        end
        m_dr = 1;
        if (is_brk) m_brk = 1;
    endtask

    task automatic op_push(input logic [7:0] b);
        step(1, b, 0, 0, 0, 0, 8'h00); m_put(b, 0);
    endtask

    task automatic op_brk();
        step(0, 8'h00, 1, 0, 0, 0, 8'h00); m_put(8'h00, 1);
    endtask

    task automatic op_read();
        step(0, 8'h00, 0, 1, 0, 0, 8'h00);
        if (m_en) begin
            m_tmo = 0;
            if (mq.size() != 0) begin
                void'(mq.pop_front());
                if (mq.size() == 0) begin m_dr = 0; m_brk = 0; end
            end
        end else begin
            m_dr = 0; m_brk = 0;
        end
    endtask

    task automatic op_lsr();
        step(0, 8'h00, 0, 0, 1, 0, 8'h00); m_ovr = 0; m_brk = 0;
    endtask

    task automatic op_cfg(input logic [7:0] v);
        step(0, 8'h00, 0, 0, 0, 1, v);
        if ((v[0] != m_en) || v[1]) begin
            mq.delete(); m_dr = 0; m_brk = 0; m_tmo = 0;
        end
        m_en = v[0]; m_trig = v[7:6];
    endtask

    // push one byte, then sample the timeout one cycle before and at the window end
    task automatic tmo_window(input logic [3:0] fmt, input logic [15:0] bp, input string req);
        int lim;
        frame_fmt = fmt; bit_period = bp;
        lim = 4 * int'(bp) * flen(fmt);
        op_cfg(8'h03);
        op_push(8'h5C);
        repeat (lim - 1) @(negedge clk);
        chk(req, "timeout_pend before window end", int'(timeout_pend), 0);
        @(negedge clk);
        chk(req, "timeout_pend at window end", int'(timeout_pend), 1);
        m_tmo = 1;
        check_all(req);
        op_read();
        check_all("R7 read clears timeout");
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234567));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state");

        // R11: single-register overwrite
        op_push(8'h11); check_all("R11");
        op_push(8'h22); check_all("R11 overwrite sets overrun");
        op_read();      check_all("R11 read clears ready");
        op_lsr();       check_all("R12 lsr clears overrun");

        // R2 / R13 / R3: queue mode order, full, drop
        op_cfg(8'h01); check_all("R10 mode change");
        for (int i = 0; i < 16; i++) begin
            op_push(8'h40 + 8'(i)); check_all("R2 fill");
        end
        chk("R13", "fill_count full", int'(fill_count), 16);
        op_push(8'hEE); check_all("R3 drop when full");
        op_brk();       check_all("R3 break dropped when full");
        for (int i = 0; i < 16; i++) begin
            check_all("R2 order");
            op_read();
        end
        check_all("R6 emptied");
        chk("R6", "rd_data empty", int'(rd_data), 0);
        op_lsr(); check_all("R12 clears after overrun");

        // R5: break in queue mode then read clears
        op_brk();  check_all("R5 break pushes zero");
        op_read(); check_all("R6 break cleared by emptying read");

        // R4: every trigger level
        for (int s = 0; s < 4; s++) begin
            op_cfg({2'(s), 6'b000011});
            for (int k = 0; k < lvl(2'(s)); k++) begin
                op_push(8'(k + 1)); check_all("R4 trigger level");
            end
            chk("R4", "trig_hit at level", int'(trig_hit), 1);
        end

        // R9 flush and R10 enable change with data held
        op_push(8'h77); op_cfg(8'hC3); check_all("R9 flush");
        op_push(8'h78); op_cfg(8'h00); check_all("R10 disable flushes");
        chk("R10", "fill_count after disable", int'(fill_count), 0);

        // random mix, long timeout window so it never ends
        frame_fmt = 4'b0000; bit_period = 16'd4000;
        op_cfg(8'h01);
        for (int n = 0; n < 700; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 45)      op_push(8'($urandom));
            else if (r < 52) op_brk();
            else if (r < 84) op_read();
            else if (r < 92) op_lsr();
            else op_cfg({2'($urandom), 4'b0000, 1'(($urandom % 6) == 0), 1'(($urandom % 8) != 0)});
            check_all("R2 random");
        end

        // R7 / R8: timeout window length from the frame format
        tmo_window(4'b0011, 16'd2, "R8 8N1");
        tmo_window(4'b1100, 16'd2, "R8 5-bit parity two stop");
        tmo_window(4'b0000, 16'd3, "R7 window");

        // R7: partial read restarts window
        frame_fmt = 4'b0011; bit_period = 16'd2;
        op_cfg(8'h03);
        op_push(8'hA1); op_push(8'hA2);
        repeat (30) @(negedge clk);
        op_read();
        repeat (79) @(negedge clk);
        chk("R7", "restart by partial read, before end", int'(timeout_pend), 0);
        @(negedge clk);
        chk("R7", "restart by partial read, at end", int'(timeout_pend), 1);
        m_tmo = 1;
        op_cfg(8'h03); check_all("R9 flush cancels timeout");

        // R7: emptied queue never times out
        op_push(8'hB0); op_read();
        repeat (90) @(negedge clk);
        chk("R7", "no timeout when empty", int'(timeout_pend), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule